// File: doc/BRIEF.md
# Page Access Rights Checker

This block decides whether one memory access may go ahead under page-level protection. For each request, a page-table walker supplies the user/supervisor and read/write bits from every table level. The pipeline supplies the current privilege level and the kind of access, which is a read, a write or an instruction fetch. A control bit turns on write protection for supervisor code. The block merges the per-level bits into one effective pair of rights and answers at once with an allow signal.

When a valid request is refused, the block raises a one-cycle fault pulse on the next clock edge. On that same edge it stores a 3-bit page-fault error code, which exception logic can read. The stored code stays unchanged until the next refused request. A not-present indication from the walker overrides the rights check.

Top module: `page_rights_check`

## Requirements
- R1: Privilege levels 0, 1 and 2 are treated as supervisor. Level 3 (`cpl == 2'd3`) is treated as user. The user flag appears as bit 2 of the error code.
- R2: The effective rights `{eff_us, eff_rw}` are the numerically smallest 2-bit value `{us, rw}` across all table levels. Index 0 is the directory level and index 1 is the table level.
- R3: A user access of any type is refused when the effective U/S bit is 0.
- R4: When the effective U/S bit is 1, a user may read and fetch. A user may write only when the effective R/W bit is 1. The access encoding is 2'b00 read, 2'b01 write, 2'b10 fetch, and 2'b11 is handled as a read.
- R5: When `wp_en` is 0, every supervisor access to a present page is allowed, whatever the R/W bit is.
- R6: When `wp_en` is 1, a supervisor write to a page whose effective R/W bit is 0 is refused. Supervisor reads and fetches are still allowed.
- R7: `fault_pulse` is high for exactly the one cycle after the clock edge that samples a request with `req_valid` high and `access_ok` low. It is low after every other edge, including edges where `req_valid` is low.
- R8: On a fault edge, `fault_code` is loaded with three bits. Bit 0 is 1 for a protection violation and 0 for a not-present page. Bit 1 is 1 for a write. Bit 2 is 1 for a user access. On all other edges `fault_code` holds its value.
- R9: `not_present` high makes `access_ok` low whatever the rights are, and the resulting code has bit 0 = 0.
- R10: During and right after reset, `fault_pulse` and `fault_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| lvl_us | input | LEVELS | U/S bit per table level (0 = directory) |
| lvl_rw | input | LEVELS | R/W bit per table level |
| cpl | input | 2 | Current privilege level |
| acc_type | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| wp_en | input | 1 | Supervisor write protection enable |
| not_present | input | 1 | Walker found the page not present |
| access_ok | output | 1 | Combinational allow decision |
| eff_us | output | 1 | Effective U/S bit after combining levels |
| eff_rw | output | 1 | Effective R/W bit after combining levels |
| fault_pulse | output | 1 | Registered one-cycle fault indication |
| fault_code | output | 3 | Registered page-fault error code |

## Verification
The assertions watch the timing on every cycle. They check that a refused valid request always gives a pulse on the next edge and that no other edge does. They check that the stored code stays unchanged between faults and that the write bit and the not-present bit 0 are captured correctly. They also check that the effective rights never exceed any single level, that supervisors are never refused without write protection, and that users never pass a U/S = 0 page. Only the bench scenarios can show the full decision table. The bench walks every rights, privilege, access-type, write-protect and presence combination and compares the effective-rights value and each captured code against an independent model.

// File: rtl/prt_pkg.sv
package prt_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    localparam int ERR_W = 3;

    // Registered state of the checker
    typedef struct packed {
        logic             pulse;
        logic [ERR_W-1:0] code;
    } prt_state_s;

endpackage

// File: rtl/prt_combine.sv
module prt_combine #(
    parameter int LEVELS = 2
) (
    input  logic [LEVELS-1:0] us_i,
    input  logic [LEVELS-1:0] rw_i,
    output logic              eff_us_o,
    output logic              eff_rw_o
);
    logic [1:0] lowest;

    // Most restrictive pair: numerically smallest {us, rw}
    always_comb begin
        lowest = {us_i[0], rw_i[0]};
        for (int i = 1; i < LEVELS; i++) begin
            if ({us_i[i], rw_i[i]} < lowest) begin
                lowest = {us_i[i], rw_i[i]};
            end
        end
    end

    assign eff_us_o = lowest[1];
    assign eff_rw_o = lowest[0];

endmodule

// File: rtl/prt_decide.sv
module prt_decide
    import prt_pkg::*;
#(
    parameter int CPL_W      = 2,
    parameter int USER_LEVEL = 3
) (
    input  logic             eff_us_i,
    input  logic             eff_rw_i,
    input  logic [CPL_W-1:0] cpl_i,
    input  acc_e             acc_i,
    input  logic             wp_i,
    input  logic             np_i,
    output logic             allow_o,
    output logic             is_user_o,
    output logic             is_write_o
);
    logic rights_ok;

    assign is_user_o  = (cpl_i == CPL_W'(USER_LEVEL));
    assign is_write_o = (acc_i == ACC_WRITE);

    always_comb begin
        if (is_user_o) begin
            rights_ok = eff_us_i && (!is_write_o || eff_rw_i);
        end else begin
            rights_ok = !is_write_o || !wp_i || eff_rw_i;
        end
        allow_o = !np_i && rights_ok;
    end

endmodule

// File: rtl/page_rights_check.sv
module page_rights_check
    import prt_pkg::*;
#(
    parameter int LEVELS     = 2,
    parameter int CPL_W      = 2,
    parameter int USER_LEVEL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LEVELS-1:0] lvl_us,
    input  logic [LEVELS-1:0] lvl_rw,
    input  logic [CPL_W-1:0]  cpl,
    input  logic [1:0]        acc_type,
    input  logic              wp_en,
    input  logic              not_present,
    output logic              access_ok,
    output logic              eff_us,
    output logic              eff_rw,
    output logic              fault_pulse,
    output logic [ERR_W-1:0]  fault_code
);
    localparam int CODE_PROT  = 0;
    localparam int CODE_WRITE = 1;
    localparam int CODE_USER  = 2;

    logic       is_user;
    logic       is_write;
    prt_state_s st_d;
    prt_state_s st_q;

    prt_combine #(
        .LEVELS(LEVELS)
    ) u_combine (
        .us_i    (lvl_us),
        .rw_i    (lvl_rw),
        .eff_us_o(eff_us),
        .eff_rw_o(eff_rw)
    );

    prt_decide #(
        .CPL_W     (CPL_W),
        .USER_LEVEL(USER_LEVEL)
    ) u_decide (
        .eff_us_i  (eff_us),
        .eff_rw_i  (eff_rw),
        .cpl_i     (cpl),
        .acc_i     (acc_e'(acc_type)),
        .wp_i      (wp_en),
        .np_i      (not_present),
        .allow_o   (access_ok),
        .is_user_o (is_user),
        .is_write_o(is_write)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = req_valid && !access_ok;
        if (req_valid && !access_ok) begin
            st_d.code[CODE_PROT]  = !not_present;
            st_d.code[CODE_WRITE] = is_write;
            st_d.code[CODE_USER]  = is_user;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_pulse = st_q.pulse;
    assign fault_code  = st_q.code;

endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
    parameter int LEVELS     = 2,
    parameter int CPL_W      = 2,
    parameter int USER_LEVEL = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LEVELS-1:0] lvl_us,
    input logic [LEVELS-1:0] lvl_rw,
    input logic [CPL_W-1:0]  cpl,
    input logic [1:0]        acc_type,
    input logic              wp_en,
    input logic              not_present,
    input logic              access_ok,
    input logic              eff_us,
    input logic              eff_rw,
    input logic              fault_pulse,
    input logic [2:0]        fault_code
);
    // R2: effective rights never exceed any one level
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        a_r2_no_wider_than_level: assert property (@(posedge clk) disable iff (!rst_n)
            {eff_us, eff_rw} <= {lvl_us[g], lvl_rw[g]});
    end

    a_r3_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl == CPL_W'(USER_LEVEL) && !eff_us) |-> !access_ok);

    a_r5_sup_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl != CPL_W'(USER_LEVEL) && !wp_en && !not_present) |-> access_ok);

    a_r7_pulse_after_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !access_ok) |=> fault_pulse);

    a_r7_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !access_ok) |=> !fault_pulse);

    a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !access_ok) |=> $stable(fault_code));

    a_r8_write_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !access_ok) |=> (fault_code[1] == $past(acc_type == 2'b01)));

    a_r9_absent_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && not_present) |=> (fault_pulse && !fault_code[0]));

endmodule

bind page_rights_check prt_checker #(
    .LEVELS    (LEVELS),
    .CPL_W     (CPL_W),
    .USER_LEVEL(USER_LEVEL)
) u_prt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .lvl_us     (lvl_us),
    .lvl_rw     (lvl_rw),
    .cpl        (cpl),
    .acc_type   (acc_type),
    .wp_en      (wp_en),
    .not_present(not_present),
    .access_ok  (access_ok),
    .eff_us     (eff_us),
    .eff_rw     (eff_rw),
    .fault_pulse(fault_pulse),
    .fault_code (fault_code)
);

// File: tb/page_rights_check_tb_top.sv
module page_rights_check_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEVELS     = 2;

    typedef struct {
        logic       pulse;
        logic [2:0] code;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] lvl_us = '0;
    logic [1:0] lvl_rw = '0;
    logic [1:0] cpl = '0;
    logic [1:0] acc_type = '0;
    logic       wp_en = 1'b0;
    logic       not_present = 1'b0;
    logic       access_ok, eff_us, eff_rw, fault_pulse;
    logic [2:0] fault_code;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    item_t exp_q[$];
    logic [2:0] held_code = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_rights_check #(.LEVELS(LEVELS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .lvl_us(lvl_us), .lvl_rw(lvl_rw), .cpl(cpl), .acc_type(acc_type),
        .wp_en(wp_en), .not_present(not_present), .access_ok(access_ok),
        .eff_us(eff_us), .eff_rw(eff_rw), .fault_pulse(fault_pulse),
        .fault_code(fault_code)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Independent reference from the requirements
    function automatic logic ref_allow(logic [1:0] eff, logic user, logic [1:0] acc,
                                       logic wp, logic np);
        logic wr;
        wr = (acc == 2'b01);
        if (np) return 1'b0;
        if (user) begin
            if (!eff[1]) return 1'b0;
            return wr ? eff[0] : 1'b1;
        end
        if (wr && wp && !eff[0]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic drive(logic v, logic [1:0] us, logic [1:0] rw, logic [1:0] pl,
                         logic [1:0] acc, logic wp, logic np, string tag);
        logic [1:0] d, t, eff;
        logic       ok, user;
        item_t      it;
        @(negedge clk);
        req_valid = v; lvl_us = us; lvl_rw = rw; cpl = pl;
        acc_type = acc; wp_en = wp; not_present = np;
        #1;
        d    = {us[0], rw[0]};
        t    = {us[1], rw[1]};
        eff  = (d < t) ? d : t;
        user = (pl == 2'd3);
        ok   = ref_allow(eff, user, acc, wp, np);
        chk("R2 effective rights", {6'b0, eff_us, eff_rw}, {6'b0, eff});
        chk(tag, {7'b0, access_ok}, {7'b0, ok});
        if (v && !ok) held_code = {user, acc == 2'b01, !np};
        it.pulse = v && !ok;
        it.code  = held_code;
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compares registered outputs one edge after each drive
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk({"R7 pulse / ", it.tag}, {7'b0, fault_pulse}, {7'b0, it.pulse});
                chk({"R8 code / ", it.tag}, {5'b0, fault_code}, {5'b0, it.code});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        #2;
        chk("R10 reset pulse", {7'b0, fault_pulse}, 8'd0);
        chk("R10 reset code", {5'b0, fault_code}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 after release", {4'b0, fault_pulse, fault_code}, 8'd0);

        // Directed cases: us/rw index 0 = directory, 1 = table
        drive(1, 2'b11, 2'b11, 2'd2, 2'b00, 0, 1, "R1 level 2 is supervisor");
        drive(1, 2'b11, 2'b11, 2'd3, 2'b00, 0, 1, "R1 level 3 is user");
        drive(1, 2'b11, 2'b01, 2'd3, 2'b01, 0, 0, "R2 table read-only limits user write");
        drive(1, 2'b10, 2'b11, 2'd3, 2'b00, 0, 0, "R3 user read of supervisor page");
        drive(1, 2'b11, 2'b00, 2'd3, 2'b10, 0, 0, "R4 user fetch read-only");
        drive(1, 2'b11, 2'b11, 2'd3, 2'b01, 0, 0, "R4 user write writable");
        drive(1, 2'b00, 2'b00, 2'd0, 2'b01, 0, 0, "R5 supervisor write no wp");
        drive(1, 2'b11, 2'b00, 2'd1, 2'b01, 1, 0, "R6 supervisor write wp");
        drive(1, 2'b11, 2'b00, 2'd1, 2'b00, 1, 0, "R6 supervisor read wp");
        drive(0, 2'b10, 2'b10, 2'd3, 2'b01, 1, 0, "R7 invalid request ignored");
        drive(0, 2'b00, 2'b00, 2'd3, 2'b00, 0, 0, "R7 idle");
        drive(1, 2'b11, 2'b11, 2'd0, 2'b01, 1, 1, "R9 not present overrides");

        // Full sweep
        for (int r = 0; r < 16; r++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 3; a++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int n = 0; n < 2; n++) begin
                            logic [1:0] us, rw, eff;
                            us  = {r[3], r[1]};
                            rw  = {r[2], r[0]};
                            eff = (r[1:0] < r[3:2]) ? r[1:0] : r[3:2];
                            if (n != 0)       tag = "R9 sweep";
                            else if (p == 3)  tag = eff[1] ? "R4 sweep" : "R3 sweep";
                            else              tag = (w != 0) ? "R6 sweep" : "R5 sweep";
                            drive(1, us, rw, 2'(p), 2'(a), w[0], n[0], tag);
                        end
                    end
                end
            end
        end
        drive(0, 2'b00, 2'b00, 2'd0, 2'b00, 0, 0, "R7 final idle");
        drive(0, 2'b00, 2'b00, 2'd0, 2'b00, 0, 0, "R7 final idle");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule